// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from up to sixteen peripheral sources into a sticky status register and gates them with a mask register. It raises one interrupt line toward the processor while any bit is pending in status and enabled in mask. Software reaches both registers through a small register bus that carries 16-bit and 32-bit accesses.

Software acknowledges an interrupt by writing to the status register. The write keeps only those bits that are 1 in the written value and also enabled in the current mask. Every other bit is cleared. Two configuration straps can force the serial source (bit 7) and the sound source (bit 9) pending just before each acknowledge is applied. Bit 3 is the input used by the DMA interrupt unit.

When software writes a new mask that exposes a source which is already pending, the block gives a one-cycle recheck strobe. This tells the processor side to look at its interrupt state again.

Top module: `intc_status_mask`

## Requirements
- R1: After reset, status and mask read as 0, and both `cpu_irq` and `recheck_pulse` are low.
- R2: A 1 on bit i of `src_req` at a clock edge sets status bit i. A status bit stays set until a status write clears it.
- R3: A write to the status register (offset 0x070) makes status equal to the old status AND mask AND the low 16 bits of the written value.
- R4: When `strap_serial` is high, status bit 7 is taken as 1 before the acknowledge of R3 is applied. When `strap_sound` is high, status bit 9 is treated the same way.
- R5: A request on `src_req` in the same cycle as a status write leaves that status bit set.
- R6: A write to the mask register (offset 0x074) stores the low 16 bits of the written value unchanged. This holds for both 16-bit (`bus_size`=0) and 32-bit (`bus_size`=1) writes.
- R7: `recheck_pulse` is high for exactly the one cycle after a mask write, and only when the resulting status AND the new mask is nonzero.
- R8: `cpu_irq` equals the OR of (status AND mask) as those registers stand after each clock edge.
- R9: Reads return status or mask zero-extended to 32 bits. A 16-bit access to the upper halfword (address bit 1 set) is treated as outside the registers. Accesses to any other offset read as 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | ADDR_W | Byte offset within the I/O window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_req | input | 16 | Peripheral request pulses, one per source |
| strap_serial | input | 1 | Forces serial bit 7 pending before each acknowledge |
| strap_sound | input | 1 | Forces sound bit 9 pending before each acknowledge |
| cpu_irq | output | 1 | Registered interrupt request to the processor |
| recheck_pulse | output | 1 | One-cycle strobe after a mask write that exposes a pending bit |

## Verification
The bench looks at how an acknowledge interacts with the mask. If a design ignored the mask during an acknowledge, bits that software has masked would stay pending. If it applied the straps after the AND instead of before it, bits 7 and 9 would be left set even when masked.

The bench also fires a request in the same cycle as a clearing write. A design that gave the write priority would lose that event.

It checks mask writes both with and without a pending source. A wrong strobe condition would either miss the recheck or fire it spuriously.

It aims upper-halfword and off-map accesses at the registers. A loose address decoder would let these corrupt the mask or return data where none should appear.

// File: rtl/intc_pkg.sv
package intc_pkg;
    parameter int unsigned SRC_W  = 16;
    parameter int unsigned DATA_W = 32;

    typedef logic [SRC_W-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t stat;
        src_vec_t mask;
        logic     irq;
        logic     recheck;
    } intc_state_t;
endpackage

// File: rtl/intc_bus_decode.sv
module intc_bus_decode #(
    parameter int unsigned         ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]   STAT_OFS = 12'h070,
    parameter logic [ADDR_W-1:0]   MASK_OFS = 12'h074
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              stat_wr,
    output logic              mask_wr,
    output logic              stat_hit,
    output logic              mask_hit
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_addr;
    logic              lane_ok;
    logic              byte_bit_unused;

    assign word_addr       = bus_addr[ADDR_W-1:2];
    assign byte_bit_unused = bus_addr[0];
    // 32-bit accesses take the whole word; 16-bit only the low halfword lane.
    assign lane_ok  = bus_size || !bus_addr[1];
    assign stat_hit = bus_sel && lane_ok && (word_addr == STAT_OFS[ADDR_W-1:2]);
    assign mask_hit = bus_sel && lane_ok && (word_addr == MASK_OFS[ADDR_W-1:2]);
    assign stat_wr  = stat_hit && bus_we;
    assign mask_wr  = mask_hit && bus_we;
endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
#(
    parameter int unsigned SER_BIT = 7,
    parameter int unsigned SND_BIT = 9
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stat_wr,
    input  logic     mask_wr,
    input  src_vec_t wr_val,
    input  src_vec_t src_req,
    input  logic     strap_serial,
    input  logic     strap_sound,
    output src_vec_t stat_q,
    output src_vec_t mask_q,
    output logic     irq_q,
    output logic     recheck_q
);
    intc_state_t state_d, state_q;
    src_vec_t    force_vec;
    src_vec_t    acked;

    // Strap-forced sources, one lane per strap.
    localparam int unsigned N_STRAP = 2;
    localparam int unsigned STRAP_POS [N_STRAP] = '{SER_BIT, SND_BIT};
    logic [N_STRAP-1:0] strap_vec;
    assign strap_vec = {strap_sound, strap_serial};

    always_comb begin
        force_vec = '0;
        for (int k = 0; k < N_STRAP; k++) begin
            if (strap_vec[k]) force_vec[STRAP_POS[k]] = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        acked   = state_q.stat;
        if (stat_wr) begin
            acked = (state_q.stat | force_vec) & state_q.mask & wr_val;
        end
        state_d.stat = acked | src_req;
        if (mask_wr) begin
            state_d.mask = wr_val;
        end
        state_d.irq     = |(state_d.stat & state_d.mask);
        state_d.recheck = mask_wr && (|(state_d.stat & wr_val));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_q    = state_q.stat;
    assign mask_q    = state_q.mask;
    assign irq_q     = state_q.irq;
    assign recheck_q = state_q.recheck;
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
    import intc_pkg::*;
(
    input  logic              bus_we,
    input  logic              stat_hit,
    input  logic              mask_hit,
    input  src_vec_t          stat_q,
    input  src_vec_t          mask_q,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned PAD_W = DATA_W - SRC_W;

    always_comb begin
        bus_rdata = '0;
        if (!bus_we) begin
            if (stat_hit)      bus_rdata = {{PAD_W{1'b0}}, stat_q};
            else if (mask_hit) bus_rdata = {{PAD_W{1'b0}}, mask_q};
        end
    end
endmodule

// File: rtl/intc_status_mask.sv
module intc_status_mask
    import intc_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074,
    parameter int unsigned       SER_BIT  = 7,
    parameter int unsigned       SND_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       src_req,
    input  logic              strap_serial,
    input  logic              strap_sound,
    output logic              cpu_irq,
    output logic              recheck_pulse
);
    logic     stat_wr, mask_wr, stat_hit, mask_hit;
    src_vec_t stat_q, mask_q;
    src_vec_t wr_val;
    logic     wdata_hi_unused;

    assign wr_val          = bus_wdata[SRC_W-1:0];
    assign wdata_hi_unused = ^bus_wdata[DATA_W-1:SRC_W];

    intc_bus_decode #(
        .ADDR_W  (ADDR_W),
        .STAT_OFS(STAT_OFS),
        .MASK_OFS(MASK_OFS)
    ) u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_size(bus_size),
        .bus_addr(bus_addr),
        .stat_wr (stat_wr),
        .mask_wr (mask_wr),
        .stat_hit(stat_hit),
        .mask_hit(mask_hit)
    );

    intc_core #(
        .SER_BIT(SER_BIT),
        .SND_BIT(SND_BIT)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_wr     (stat_wr),
        .mask_wr     (mask_wr),
        .wr_val      (wr_val),
        .src_req     (src_req),
        .strap_serial(strap_serial),
        .strap_sound (strap_sound),
        .stat_q      (stat_q),
        .mask_q      (mask_q),
        .irq_q       (cpu_irq),
        .recheck_q   (recheck_pulse)
    );

    intc_read_mux u_rd (
        .bus_we   (bus_we),
        .stat_hit (stat_hit),
        .mask_hit (mask_hit),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/intc_status_mask_chk.sv
module intc_status_mask_chk #(
    parameter int unsigned       ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074,
    parameter int unsigned       SER_BIT  = 7,
    parameter int unsigned       SND_BIT  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic              bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [15:0]       src_req,
    input logic              strap_serial,
    input logic              strap_sound,
    input logic              cpu_irq,
    input logic              recheck_pulse,
    input logic [15:0]       stat_q,
    input logic [15:0]       mask_q
);
    logic        lane32;
    logic        s_wr, m_wr;
    logic [15:0] strap_bits;

    assign lane32 = bus_size || !bus_addr[1];
    assign s_wr = bus_sel && bus_we && lane32 && (bus_addr[ADDR_W-1:2] == STAT_OFS[ADDR_W-1:2]);
    assign m_wr = bus_sel && bus_we && lane32 && (bus_addr[ADDR_W-1:2] == MASK_OFS[ADDR_W-1:2]);

    always_comb begin
        strap_bits = '0;
        strap_bits[SER_BIT] = strap_serial;
        strap_bits[SND_BIT] = strap_sound;
    end

    // R2: requests land in status on the next edge.
    assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat_q & $past(src_req)) == $past(src_req)));

    // R2: without a status write, no pending bit is lost.
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(s_wr)) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R3/R4: after an acknowledge, only masked-and-written or newly requested bits survive.
    assert_ack_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(s_wr)) |->
        ((stat_q & ~$past(src_req) & ~($past(mask_q) & $past(bus_wdata[15:0])
          & ($past(stat_q) | $past(strap_bits)))) == 16'h0));

    // R6: mask takes the written low half.
    assert_mask_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(m_wr)) |-> (mask_q == $past(bus_wdata[15:0])));

    // R7: the strobe only follows a mask write that exposes a pending bit.
    assert_recheck_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recheck_pulse |-> ($past(rst_n) && $past(m_wr) && ((stat_q & mask_q) != 16'h0)));

    // R8: the request line tracks the enabled pending set.
    assert_irq_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cpu_irq == ((stat_q & mask_q) != 16'h0)));
endmodule

bind intc_status_mask intc_status_mask_chk #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS),
    .SER_BIT (SER_BIT),
    .SND_BIT (SND_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_size     (bus_size),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .src_req      (src_req),
    .strap_serial (strap_serial),
    .strap_sound  (strap_sound),
    .cpu_irq      (cpu_irq),
    .recheck_pulse(recheck_pulse),
    .stat_q       (stat_q),
    .mask_q       (mask_q)
);

// File: tb/sim_intc_status_mask.sv
module sim_intc_status_mask;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_size = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] src_req = '0;
    logic        strap_serial = 1'b0;
    logic        strap_sound = 1'b0;
    logic        cpu_irq;
    logic        recheck_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intc_status_mask u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_req(src_req), .strap_serial(strap_serial),
        .strap_sound(strap_sound), .cpu_irq(cpu_irq), .recheck_pulse(recheck_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic sz, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic sz, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_size = sz; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_req(input logic [15:0] v);
        @(negedge clk);
        src_req = v;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 irq", {31'b0, cpu_irq}, 32'h0);
        check("R1 recheck", {31'b0, recheck_pulse}, 32'h0);
        bus_read(12'h070, 1'b1, r); check("R1 status", r, 32'h0);
        bus_read(12'h074, 1'b1, r); check("R1 mask", r, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] r;
        pulse_req(16'h0088);
        pulse_req(16'h0001);
        @(negedge clk);
        bus_read(12'h070, 1'b1, r); check("R2 sticky status", r, 32'h0000_0089);
        check("R8 irq off with mask 0", {31'b0, cpu_irq}, 32'h0);
    endtask

    task automatic t_mask_expose();
        logic [31:0] r;
        bus_write(12'h074, 1'b1, 32'hABCD_0008);
        check("R7 recheck after exposing mask", {31'b0, recheck_pulse}, 32'h1);
        check("R8 irq on", {31'b0, cpu_irq}, 32'h1);
        @(negedge clk);
        check("R7 recheck lasts one cycle", {31'b0, recheck_pulse}, 32'h0);
        bus_read(12'h074, 1'b1, r); check("R6 mask 32-bit low half", r, 32'h0000_0008);
    endtask

    task automatic t_ack();
        logic [31:0] r;
        bus_write(12'h070, 1'b0, 32'h0000_FFFF);
        bus_read(12'h070, 1'b1, r); check("R3 ack keeps masked bits only", r, 32'h0000_0008);
        check("R8 irq still on", {31'b0, cpu_irq}, 32'h1);
        bus_write(12'h070, 1'b1, 32'h0000_0000);
        bus_read(12'h070, 1'b1, r); check("R3 ack with zero clears", r, 32'h0);
        check("R8 irq off after clear", {31'b0, cpu_irq}, 32'h0);
    endtask

    task automatic t_straps();
        logic [31:0] r;
        bus_write(12'h074, 1'b1, 32'h0000_0280);
        check("R7 no recheck with nothing pending", {31'b0, recheck_pulse}, 32'h0);
        strap_serial = 1'b1; strap_sound = 1'b1;
        bus_write(12'h070, 1'b1, 32'h0000_FFFF);
        bus_read(12'h070, 1'b1, r); check("R4 straps force bits 7 and 9", r, 32'h0000_0280);
        check("R8 irq from forced bits", {31'b0, cpu_irq}, 32'h1);
        strap_serial = 1'b0; strap_sound = 1'b0;
        bus_write(12'h070, 1'b1, 32'h0);
        bus_read(12'h070, 1'b1, r); check("R4 no force without straps", r, 32'h0);
    endtask

    task automatic t_offmap();
        logic [31:0] r;
        bus_write(12'h076, 1'b0, 32'h1234_1234);
        bus_write(12'h078, 1'b1, 32'h0000_FFFF);
        bus_read(12'h074, 1'b1, r); check("R9 stray writes leave mask", r, 32'h0000_0280);
        bus_read(12'h076, 1'b0, r); check("R9 upper halfword reads 0", r, 32'h0);
        bus_read(12'h07C, 1'b1, r); check("R9 unmapped reads 0", r, 32'h0);
    endtask

    task automatic t_mask16_and_race();
        logic [31:0] r;
        bus_write(12'h074, 1'b0, 32'hDEAD_0010);
        bus_read(12'h074, 1'b1, r); check("R6 mask 16-bit write", r, 32'h0000_0010);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_size = 1'b1; bus_addr = 12'h070;
        bus_wdata = 32'h0; src_req = 16'h0010;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; src_req = '0;
        bus_read(12'h070, 1'b0, r); check("R5 request beats ack", r, 32'h0000_0010);
        check("R8 irq from raced bit", {31'b0, cpu_irq}, 32'h1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_mask_expose();
        t_ack();
        t_straps();
        t_offmap();
        t_mask16_and_race();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule